// File: doc/BRIEF.md
# Clock-Bias Discipline Controller

This block closes the software-free part of an oscillator discipline loop. Once per update strobe it takes a signed clock-bias sample in picoseconds from a timing receiver. It forms an error term and runs it through proportional, integral and (optionally) derivative paths. It then registers a signed 24-bit frequency-control word for a digitally controlled oscillator. A positive bias means local time runs ahead, so the loop is signed to pull the control word down for a positive bias and up for a negative one.

Two error sources are selectable. With `phaseMode` low the loop locks frequency: the error is the previous committed bias minus the new bias, so a drifting bias is driven to a constant. With `phaseMode` high the loop locks phase: the error is the setpoint minus the bias. Gains are unsigned fixed-point inputs with 8 fraction bits. The integrator saturates at a programmable symmetric bound. A hold input, raised while the receiver reports a fault, makes a strobe leave every piece of loop state untouched.

Top module: `clk_bias_loop`

## Requirements
- R1: After reset `ctrlOut` is 0, and the integrator, previous-bias and previous-error registers are all zero.
- R2: With `phaseMode` = 1 the error is `setpointIn - biasIn`, so with setpoint 0 a positive bias gives a negative proportional contribution and a negative bias a positive one.
- R3: With `phaseMode` = 0 the error is the bias of the last committed sample minus `biasIn`; the first committed sample after reset uses an error of 0, because no prior sample exists.
- R4: The proportional contribution is `kpIn * error`, with `kpIn` unsigned and 8 fraction bits (256 = 1.0).
- R5: On each committed sample the integrator becomes `integrator + kiIn * error`, clamped to the range [-`intLimit`, +`intLimit`] in the same scaled units; the output uses the updated value.
- R6: With parameter `DERIV_EN` = 1 a term `kdIn * (error - previous error)` is added; the previous error is the error of the last committed sample (0 after reset).
- R7: `ctrlOut` is the sum of the terms arithmetically shifted right by 8 (rounding toward minus infinity), saturated to [-8388608, 8388607].
- R8: A strobe with `holdIn` = 1 changes nothing: not the output, the integrator, the previous bias, the previous error, or the first-sample state.
- R9: A committed sample (`sampleValid` = 1, `holdIn` = 0) updates `ctrlOut` at that clock edge; without one, `ctrlOut` keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Update strobe: a new bias sample is present |
| holdIn | input | 1 | Freeze request; a strobe while high is discarded |
| phaseMode | input | 1 | 0 = frequency lock (bias change), 1 = phase lock (setpoint minus bias) |
| biasIn | input | 32 | Signed receiver clock bias, picoseconds |
| setpointIn | input | 32 | Signed phase-lock target bias, picoseconds |
| kpIn | input | 16 | Proportional gain, unsigned, 8 fraction bits |
| kiIn | input | 16 | Integral gain, unsigned, 8 fraction bits |
| kdIn | input | 16 | Derivative gain, unsigned, 8 fraction bits |
| intLimit | input | 47 | Integrator magnitude bound in scaled units |
| ctrlOut | output | 24 | Signed oscillator control word |

## Verification
A hold strobe can arrive in the same cycle as a mode change or a new gain set, and the hold must win over both. The bench raises hold together with sampleValid, while it flips phaseMode and rewrites the bias and the gains, both in directed steps and at random within the seeded run. It judges the outcome at the ports in two ways: the control word must not move, and the next unheld sample must produce exactly the value a model predicts from the state before the held strobe. That sample proves the previous-bias, previous-error and integrator registers were left alone. The integrator clamp and the output saturation also meet in single samples with extreme bias and full-scale gains, and each is judged against the model.

// File: rtl/clk_bias_loop_pkg.sv
`timescale 1ns/1ps
package clk_bias_loop_pkg;
  // Strobes from the loop sequencer to the arithmetic
  typedef struct packed {
    logic commit;    // take this sample into the loop state
    logic usePhase;  // error = setpoint - bias
    logic zeroErr;   // frequency lock with no prior sample: error is zero
  } loopStrobes_t;
endpackage

// File: rtl/clk_bias_loop_ctrl.sv
`timescale 1ns/1ps
module clk_bias_loop_ctrl
  import clk_bias_loop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         holdIn,
  input  logic         phaseMode,
  output loopStrobes_t strobes
);
  logic primed;

  always_comb begin
    strobes.commit   = sampleValid && !holdIn;
    strobes.usePhase = phaseMode;
    strobes.zeroErr  = !phaseMode && !primed;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              primed <= 1'b0;
    else if (strobes.commit) primed <= 1'b1;
  end

  AST_PRIME_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> primed);  // R3
  AST_PRIME_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    primed |=> primed);  // R3
  AST_HOLD_NO_PRIME: assert property (@(posedge clk) disable iff (!rstN)
    (holdIn && !primed) |=> !primed);  // R8
endmodule

// File: rtl/clk_bias_loop_dp.sv
`timescale 1ns/1ps
module clk_bias_loop_dp
  import clk_bias_loop_pkg::*;
#(
  parameter int BIAS_W   = 32,
  parameter int GAIN_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int OUT_W    = 24,
  parameter int INT_W    = 48,
  parameter int ACC_W    = 64,
  parameter bit DERIV_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  loopStrobes_t             strobes,
  input  logic signed [BIAS_W-1:0] biasIn,
  input  logic signed [BIAS_W-1:0] setpointIn,
  input  logic [GAIN_W-1:0]        kpIn,
  input  logic [GAIN_W-1:0]        kiIn,
  input  logic [GAIN_W-1:0]        kdIn,
  input  logic [INT_W-2:0]         intLimit,
  output logic signed [OUT_W-1:0]  ctrlOut
);
  localparam int ERR_W = BIAS_W + 1;
  localparam logic signed [ACC_W-1:0] OUT_MAX =
    ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - 1;

  logic signed [BIAS_W-1:0] prevBias;
  logic signed [ERR_W-1:0]  prevErr;
  logic signed [INT_W-1:0]  integ;

  logic signed [ERR_W-1:0]  errNow;
  logic signed [ACC_W-1:0]  errAcc, kpAcc, kiAcc, limAcc;
  logic signed [ACC_W-1:0]  pTerm, dTerm, intSum, intClamped, sumAcc, shifted, outSat;
  logic signed [INT_W-1:0]  intNext;

  // Error source select; sign chosen so a positive bias pulls the word down
  always_comb begin
    if (strobes.zeroErr)       errNow = '0;
    else if (strobes.usePhase) errNow = ERR_W'(setpointIn) - ERR_W'(biasIn);
    else                       errNow = ERR_W'(prevBias) - ERR_W'(biasIn);
  end

  always_comb begin
    errAcc = ACC_W'(errNow);
    kpAcc  = ACC_W'($signed({1'b0, kpIn}));
    kiAcc  = ACC_W'($signed({1'b0, kiIn}));
    limAcc = ACC_W'($signed({1'b0, intLimit}));
    pTerm  = errAcc * kpAcc;
    intSum = ACC_W'(integ) + errAcc * kiAcc;
    if (intSum > limAcc)       intClamped = limAcc;
    else if (intSum < -limAcc) intClamped = -limAcc;
    else                       intClamped = intSum;
    intNext = INT_W'(intClamped);
  end

  generate
    if (DERIV_EN) begin : g_deriv
      logic signed [ACC_W-1:0] kdAcc, dErr;
      always_comb begin
        kdAcc = ACC_W'($signed({1'b0, kdIn}));
        dErr  = errAcc - ACC_W'(prevErr);
        dTerm = dErr * kdAcc;
      end
    end else begin : g_no_deriv
      assign dTerm = '0;
    end
  endgenerate

  always_comb begin
    sumAcc  = pTerm + ACC_W'(intNext) + dTerm;
    shifted = sumAcc >>> FRAC_W;
    if (shifted > OUT_MAX)      outSat = OUT_MAX;
    else if (shifted < OUT_MIN) outSat = OUT_MIN;
    else                        outSat = shifted;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlOut  <= '0;
      integ    <= '0;
      prevBias <= '0;
      prevErr  <= '0;
    end else if (strobes.commit) begin
      ctrlOut  <= OUT_W'(outSat);
      integ    <= intNext;
      prevBias <= biasIn;
      prevErr  <= errNow;
    end
  end

  AST_QUIET_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(ctrlOut) && $stable(integ) && $stable(prevBias) && $stable(prevErr)));  // R8
  AST_PREV_BIAS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (prevBias == $past(biasIn)));  // R3
  AST_INT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> ((ACC_W'(integ) <= ACC_W'($signed({1'b0, $past(intLimit)}))) &&
                        (ACC_W'(integ) >= -ACC_W'($signed({1'b0, $past(intLimit)})))));  // R5
  AST_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && strobes.zeroErr) |=> (prevErr == '0));  // R3
endmodule

// File: rtl/clk_bias_loop.sv
`timescale 1ns/1ps
module clk_bias_loop
  import clk_bias_loop_pkg::*;
#(
  parameter int BIAS_W   = 32,
  parameter int GAIN_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int OUT_W    = 24,
  parameter int INT_W    = 48,
  parameter int ACC_W    = 64,
  parameter bit DERIV_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic                     holdIn,
  input  logic                     phaseMode,
  input  logic signed [BIAS_W-1:0] biasIn,
  input  logic signed [BIAS_W-1:0] setpointIn,
  input  logic [GAIN_W-1:0]        kpIn,
  input  logic [GAIN_W-1:0]        kiIn,
  input  logic [GAIN_W-1:0]        kdIn,
  input  logic [INT_W-2:0]         intLimit,
  output logic signed [OUT_W-1:0]  ctrlOut
);
  loopStrobes_t strobes;

  clk_bias_loop_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .holdIn(holdIn), .phaseMode(phaseMode), .strobes(strobes)
  );

  clk_bias_loop_dp #(
    .BIAS_W(BIAS_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W),
    .INT_W(INT_W), .ACC_W(ACC_W), .DERIV_EN(DERIV_EN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .biasIn(biasIn),
    .setpointIn(setpointIn), .kpIn(kpIn), .kiIn(kiIn), .kdIn(kdIn),
    .intLimit(intLimit), .ctrlOut(ctrlOut)
  );
endmodule

// File: tb/clk_bias_loop_tb_top.sv
`timescale 1ns/1ps
module clk_bias_loop_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0, holdIn = 1'b0, phaseMode = 1'b0;
  logic signed [31:0] biasIn = '0, setpointIn = '0;
  logic [15:0] kpIn = '0, kiIn = '0, kdIn = '0;
  logic [46:0] intLimit = '0;
  logic signed [23:0] ctrlOut;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // model state
  longint mInt = 0, mPrevBias = 0, mPrevErr = 0, mOut = 0;
  bit mPrimed = 1'b0;

  always #2.5 clk = ~clk;

  clk_bias_loop dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .holdIn(holdIn),
    .phaseMode(phaseMode), .biasIn(biasIn), .setpointIn(setpointIn),
    .kpIn(kpIn), .kiIn(kiIn), .kdIn(kdIn), .intLimit(intLimit), .ctrlOut(ctrlOut)
  );

  function automatic longint clampL(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: ctrlOut=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one strobe; model updated only when not held
  task automatic doSample(input logic signed [31:0] b, input bit h, input string tag);
    longint e, iN, de, sum, o, lim;
    if (!h) begin
      if (phaseMode) e = longint'(setpointIn) - longint'(b);
      else if (mPrimed) e = mPrevBias - longint'(b);
      else e = 0;
      lim = longint'(intLimit);
      iN  = clampL(mInt + longint'(kiIn) * e, -lim, lim);
      de  = e - mPrevErr;
      sum = longint'(kpIn) * e + iN + longint'(kdIn) * de;
      o   = clampL(sum >>> 8, -64'sd8388608, 64'sd8388607);
      mInt = iN; mPrevBias = longint'(b); mPrevErr = e; mOut = o; mPrimed = 1'b1;
    end
    biasIn = b; holdIn = h; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0; holdIn = 1'b0;
    check(tag, longint'(ctrlOut), mOut);
  endtask

  task automatic setGains(input int kp, input int ki, input int kd, input longint lim);
    kpIn = 16'(kp); kiIn = 16'(ki); kdIn = 16'(kd); intLimit = 47'(lim);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: ctrlOut=%0d expected=completion", ctrlOut);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset output", longint'(ctrlOut), 0);

    // Frequency lock, unity proportional gain
    setGains(256, 0, 0, 0);
    phaseMode = 1'b0;
    doSample(32'sd1000, 1'b1, "R8 held strobe before first sample");
    doSample(32'sd5000, 1'b0, "R3 first sample zero error");
    check("R3 first sample literal", longint'(ctrlOut), 0);
    doSample(32'sd5300, 1'b0, "R3 bias change error");
    check("R3 bias rise lowers word", longint'(ctrlOut), -300);

    // Phase lock sign
    phaseMode = 1'b1; setpointIn = 0;
    doSample(32'sd200, 1'b0, "R2 positive bias");
    check("R2 positive bias literal", longint'(ctrlOut), -200);
    doSample(-32'sd150, 1'b0, "R2 negative bias");
    check("R2 negative bias literal", longint'(ctrlOut), 150);
    setpointIn = 32'sd50;
    doSample(32'sd20, 1'b0, "R2 nonzero setpoint");

    // Integral with clamp
    setGains(0, 256, 0, 64'd64000); setpointIn = 0;
    doSample(-32'sd100, 1'b0, "R5 integrate step 1");
    check("R5 integrate literal", longint'(ctrlOut), 100);
    doSample(-32'sd100, 1'b0, "R5 integrate step 2");
    doSample(-32'sd1000, 1'b0, "R5 clamp high");
    check("R5 clamp high literal", longint'(ctrlOut), 250);
    repeat (3) doSample(32'sd1000, 1'b0, "R5 clamp low");
    check("R5 clamp low literal", longint'(ctrlOut), -250);

    // Derivative; limit 0 flushes integrator
    setGains(0, 0, 256, 0);
    doSample(32'sd0, 1'b0, "R6 derivative kick");
    doSample(32'sd0, 1'b0, "R6 derivative settles");
    check("R6 settle literal", longint'(ctrlOut), 0);

    // Fractional gain rounds down
    setGains(128, 0, 0, 0);
    doSample(32'sd3, 1'b0, "R4 half gain");
    check("R7 floor of -1.5", longint'(ctrlOut), -2);

    // Saturation both ways
    setGains(16'hFFFF, 0, 0, 0);
    doSample(32'h8000_0000, 1'b0, "R7 saturate high");
    check("R7 high rail", longint'(ctrlOut), 8388607);
    doSample(32'h7FFF_FFFF, 1'b0, "R7 saturate low");
    check("R7 low rail", longint'(ctrlOut), -8388608);

    // Hold coincident with mode switch and gain change
    setGains(300, 40, 90, 64'd1000000);
    doSample(32'sd700, 1'b0, "R4 mixed gains");
    phaseMode = 1'b0; setGains(9, 9, 9, 5);
    doSample(32'sd99999, 1'b1, "R8 hold with mode flip");
    phaseMode = 1'b1; setGains(300, 40, 90, 64'd1000000);
    doSample(32'sd650, 1'b0, "R8 state intact after hold");

    // No strobe: inputs wander, output stays
    biasIn = 32'sd123456; phaseMode = 1'b0; kpIn = 16'd999;
    repeat (6) @(negedge clk);
    check("R9 idle stable", longint'(ctrlOut), mOut);

    // Seeded random run
    for (int i = 0; i < 400; i++) begin
      logic signed [31:0] b;
      int sh;
      sh = ($urandom_range(0, 7) == 0) ? 0 : 10;
      b = $signed($urandom) >>> sh;
      phaseMode = ($urandom_range(0, 3) != 0);
      setpointIn = $signed($urandom) >>> 16;
      if ($urandom_range(0, 9) == 0)
        setGains($urandom_range(0, 1023), $urandom_range(0, 255), $urandom_range(0, 511),
                 longint'($urandom_range(0, 32'h00FF_FFFF)) << $urandom_range(0, 12));
      doSample(b, ($urandom_range(0, 7) == 0), "R7 random sample");
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule